// File: doc/BRIEF.md
# HDLC Receive FIFO Access Controller

This block sits between an HDLC receiver and a microprocessor. The receiver writes the bytes of incoming frames into a 32-entry circular RAM. When a frame ends, the receiver also writes one status byte, which is stored with a marker bit. The processor does not read frames as a stream. It reads them in blocks, and the block size is chosen by a 2-bit setting. When a whole block of frame data is waiting, the controller raises a pool-full interrupt. When the end-of-frame status byte turns up before a whole block has built up, it raises a message-end interrupt instead. In that case the byte counter holds the length of the short tail, status byte included.

Only one block is offered at a time. The processor reads the bytes of the block one at a time through `rd_data`, with a strobe on `rd_en`. It then gives a release command, which frees the RAM the block used. The controller then looks for the next block, which may belong to a later short frame already waiting in the RAM. The block size is sampled when a block is offered. Changing it after the reads but before the release therefore affects only the next block.

Top module: `hfc_rx_ctrl`

## Requirements
- R1: After reset, `irq`, `irq_rpf`, `irq_rme`, `wr_overflow` and `rbc` are all 0 and the FIFO is empty.
- R2: `blk_sel` selects the block size: 2'b11 selects 4 bytes, 2'b10 selects 8, 2'b01 selects 16 and 2'b00 selects 32. A pool-full block reports that size on `rbc`.
- R3: Fewer than a block's worth of bytes, with no status byte among them, raises no interrupt. A pool-full interrupt is raised on the clock edge after the FIFO holds at least one block and no status byte lies within the first block.
- R4: A byte written with `wr_eof`=1 is stored directly after the frame's last data byte. When it is read, `rd_status` is 1; for data bytes, `rd_status` is 0.
- R5: If a status byte lies at offset k (0-based) from the oldest unreleased byte, and k+1 does not exceed the block size, the controller raises a message-end interrupt instead of pool-full, with `rbc` = k+1. This also applies when k+1 equals the block size.
- R6: While a block is being offered and no release has arrived, no new interrupt bit is set and `rbc` stays stable.
- R7: `rd_data` shows the next byte of the offered block in write order, and each `rd_en` strobe advances it by one byte. A release (`rmc`) frees exactly `rbc` bytes. The next block starts at the byte that follows them.
- R8: Several complete short frames may wait in the FIFO at the same time. Each is then delivered as its own message-end block, in arrival order.
- R9: `blk_sel` is sampled when a block is offered. A change made while a block is being offered takes effect from the next block.
- R10: A write while the FIFO holds 32 bytes drives `wr_overflow` high in that cycle and discards the byte.
- R11: A pulse on `ist_rd` clears `irq_rpf` and `irq_rme`. `irq` is high while either bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | Receiver writes one byte this cycle |
| wr_data | input | 8 | Byte from the receiver |
| wr_eof | input | 1 | Marks the byte as the end-of-frame status byte |
| wr_overflow | output | 1 | The write in this cycle was dropped because the FIFO is full |
| blk_sel | input | 2 | Block size select (11=4, 10=8, 01=16, 00=32 bytes) |
| rd_en | input | 1 | Processor consumed the byte shown on rd_data |
| rd_data | output | 8 | Current byte of the offered block |
| rd_status | output | 1 | Current byte is a status byte |
| rmc | input | 1 | Release command: frees the offered block |
| ist_rd | input | 1 | Interrupt status read; clears both interrupt bits |
| irq_rpf | output | 1 | Pool-full interrupt status |
| irq_rme | output | 1 | Message-end interrupt status |
| irq | output | 1 | Interrupt request, OR of the status bits |
| rbc | output | 6 | Byte count of the offered (or last offered) block |

## Verification
The bench targets the corner case where a frame ends exactly on a block boundary. A design that checked the status byte only beyond the block would raise pool-full there and drop the end-of-frame report. It also queues two short frames at once. A design that lost track of frame boundaries would merge them into one block or report wrong counts. It changes the block size between the last read and the release. A design that sampled the size too late would cut the first block wrong, and one that sampled it too early would keep using 4-byte blocks afterwards. Finally, it fills the RAM and writes once more. A design without an overflow guard would overwrite the oldest unread byte, and that would show up as a wrong byte in the 32-byte block read back.

// File: rtl/hfc_pkg.sv
// Shared definitions for the HDLC receive FIFO access controller.
// Assumes a FIFO depth of 32, so the largest block size fits in 6 bits.
package hfc_pkg;

    // Kind of block offered to the processor.
    typedef enum logic {
        KIND_POOL = 1'b0,
        KIND_END  = 1'b1
    } blk_kind_t;

    // Decode the block-size select into a byte count.
    function automatic int unsigned blk_bytes(input logic [1:0] sel);
        case (sel)
            2'b00:   return 32;
            2'b01:   return 16;
            2'b10:   return 8;
            default: return 4;
        endcase
    endfunction

endpackage

// File: rtl/hfc_ram.sv
// Circular byte store with one write port and one asynchronous read port.
// Each entry carries an end-of-frame marker bit. All marker bits are
// exported so that the status scanner can search them in parallel.
// Assumes that the write address and the read address are managed by the parent.
module hfc_ram #(
    parameter int DEPTH = 32,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [7:0]       wdata,
    input  logic             weof,
    input  logic [AW-1:0]    raddr,
    output logic [7:0]       rdata,
    output logic             reof,
    output logic [DEPTH-1:0] eof_map
);

    logic [7:0]       data_q [DEPTH];
    logic [DEPTH-1:0] eof_q;

    // Store the byte and its marker on a write.
    always_ff @(posedge clk) begin
        if (we) begin
            data_q[waddr] <= wdata;
            eof_q[waddr]  <= weof;
        end
    end

    // Present the addressed entry combinationally.
    always_comb begin
        rdata   = data_q[raddr];
        reof    = eof_q[raddr];
        eof_map = eof_q;
    end

endmodule

// File: rtl/hfc_scan.sv
// Finds the first end-of-frame marker among the valid entries, counting
// from the oldest unreleased byte. Returns the length from that byte up to
// and including the marker. Assumes that fill never exceeds DEPTH.
module hfc_scan #(
    parameter int DEPTH = 32,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic [DEPTH-1:0] eof_map,
    input  logic [AW-1:0]    head,
    input  logic [CW-1:0]    fill,
    output logic             found,
    output logic [CW-1:0]    first_len
);

    logic [AW-1:0] idx;

    // Priority search: the lowest offset wins, so scan downward.
    always_comb begin
        found     = 1'b0;
        first_len = '0;
        idx       = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            idx = head + AW'(i);
            if (eof_map[idx] && (CW'(i) < fill)) begin
                found     = 1'b1;
                first_len = CW'(i + 1);
            end
        end
    end

endmodule

// File: rtl/hfc_blk.sv
// Block tracker: decides when a block is offered and what kind it is.
// It latches the block length, steps the read offset, and handles the
// release command and the interrupt status bits. Assumes one block at a time.
module hfc_blk
    import hfc_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] fill,
    input  logic          found,
    input  logic [CW-1:0] first_len,
    input  logic [1:0]    blk_sel,
    input  logic          rd_en,
    input  logic          rmc,
    input  logic          ist_rd,
    output logic          presented,
    output logic [CW-1:0] blk_len,
    output logic [AW-1:0] rd_off_a,
    output logic          release_blk,
    output logic          irq_rpf,
    output logic          irq_rme
);

    logic [CW-1:0] sel_len;
    logic [CW-1:0] rd_off;
    logic          want_end;
    logic          want_pool;
    logic          start;
    blk_kind_t     kind;

    // Choose the kind of the next block from the current FIFO contents.
    always_comb begin
        sel_len     = CW'(blk_bytes(blk_sel));
        want_end    = found && (first_len <= sel_len);
        want_pool   = !want_end && (fill >= sel_len);
        start       = !presented && (want_end || want_pool);
        kind        = want_end ? KIND_END : KIND_POOL;
        release_blk = presented && rmc;
        rd_off_a    = rd_off[AW-1:0];
    end

    // Offer, read through, and release the current block.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            presented <= 1'b0;
            blk_len   <= '0;
            rd_off    <= '0;
        end else if (start) begin
            presented <= 1'b1;
            blk_len   <= (kind == KIND_END) ? first_len : sel_len;
            rd_off    <= '0;
        end else if (release_blk) begin
            presented <= 1'b0;
            rd_off    <= '0;
        end else if (presented && rd_en && (rd_off < blk_len)) begin
            rd_off <= rd_off + 1'b1;
        end
    end

    // Interrupt status bits: set on offer, cleared by a status read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_rpf <= 1'b0;
            irq_rme <= 1'b0;
        end else begin
            irq_rpf <= (start && (kind == KIND_POOL)) || (irq_rpf && !ist_rd);
            irq_rme <= (start && (kind == KIND_END))  || (irq_rme && !ist_rd);
        end
    end

endmodule

// File: rtl/hfc_rx_ctrl.sv
// Top of the HDLC receive FIFO access controller. It keeps the write
// pointer, the release pointer and the fill count of the circular RAM.
// The status scanner and the block tracker decide what the processor sees.
// Assumes DEPTH = 32 so that every block-size setting fits in the RAM.
module hfc_rx_ctrl #(
    parameter int DEPTH = 32,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_valid,
    input  logic [7:0]    wr_data,
    input  logic          wr_eof,
    output logic          wr_overflow,
    input  logic [1:0]    blk_sel,
    input  logic          rd_en,
    output logic [7:0]    rd_data,
    output logic          rd_status,
    input  logic          rmc,
    input  logic          ist_rd,
    output logic          irq_rpf,
    output logic          irq_rme,
    output logic          irq,
    output logic [CW-1:0] rbc
);

    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    head;
    logic [CW-1:0]    fill;
    logic             do_wr;
    logic [DEPTH-1:0] eof_map;
    logic             found;
    logic [CW-1:0]    first_len;
    logic             presented;
    logic [CW-1:0]    blk_len;
    logic [AW-1:0]    rd_off_a;
    logic             release_blk;
    logic [AW-1:0]    raddr;

    // Accept a write only while space is free; report a dropped byte.
    always_comb begin
        do_wr       = wr_valid && (fill != CW'(DEPTH));
        wr_overflow = wr_valid && (fill == CW'(DEPTH));
        raddr       = head + rd_off_a;
        irq         = irq_rpf || irq_rme;
        rbc         = blk_len;
    end

    // Move the pointers and the fill count on writes and releases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            head   <= '0;
            fill   <= '0;
        end else begin
            if (do_wr) wr_ptr <= wr_ptr + 1'b1;
            if (release_blk) head <= head + blk_len[AW-1:0];
            fill <= fill + CW'(do_wr) - (release_blk ? blk_len : '0);
        end
    end

    hfc_ram #(.DEPTH(DEPTH)) u_ram (
        .clk     (clk),
        .we      (do_wr),
        .waddr   (wr_ptr),
        .wdata   (wr_data),
        .weof    (wr_eof),
        .raddr   (raddr),
        .rdata   (rd_data),
        .reof    (rd_status),
        .eof_map (eof_map)
    );

    hfc_scan #(.DEPTH(DEPTH)) u_scan (
        .eof_map   (eof_map),
        .head      (head),
        .fill      (fill),
        .found     (found),
        .first_len (first_len)
    );

    hfc_blk #(.DEPTH(DEPTH)) u_blk (
        .clk         (clk),
        .rst_n       (rst_n),
        .fill        (fill),
        .found       (found),
        .first_len   (first_len),
        .blk_sel     (blk_sel),
        .rd_en       (rd_en),
        .rmc         (rmc),
        .ist_rd      (ist_rd),
        .presented   (presented),
        .blk_len     (blk_len),
        .rd_off_a    (rd_off_a),
        .release_blk (release_blk),
        .irq_rpf     (irq_rpf),
        .irq_rme     (irq_rme)
    );

endmodule

// File: rtl/hfc_rx_ctrl_chk.sv
// Property checker for hfc_rx_ctrl, attached to every instance by bind.
// Observes the ports and the fill count and offer flag of the top module.
module hfc_rx_ctrl_chk #(
    parameter int DEPTH = 32,
    localparam int CW = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_valid,
    input logic          rmc,
    input logic          presented,
    input logic [CW-1:0] fill,
    input logic [CW-1:0] rbc,
    input logic          irq_rpf,
    input logic          irq_rme
);

    AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= CW'(DEPTH)); // R10

    AST_OVF_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && fill == CW'(DEPTH) && !rmc) |=> (fill == $past(fill))); // R10

    AST_HOLD_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (presented && !rmc) |=> (presented && $stable(rbc))); // R6

    AST_NO_NEW_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (presented && !rmc) |=> (!$rose(irq_rpf) && !$rose(irq_rme))); // R6

    AST_RBC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        presented |-> (rbc != '0 && rbc <= CW'(DEPTH))); // R5

    AST_IRQ_WITH_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(irq_rpf) || $rose(irq_rme)) |-> presented); // R3

endmodule

bind hfc_rx_ctrl hfc_rx_ctrl_chk #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_valid  (wr_valid),
    .rmc       (rmc),
    .presented (presented),
    .fill      (fill),
    .rbc       (rbc),
    .irq_rpf   (irq_rpf),
    .irq_rme   (irq_rme)
);

// File: tb/tb_hfc_rx_ctrl.sv
module tb_hfc_rx_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = '0;
    logic       wr_eof = 1'b0;
    logic       wr_overflow;
    logic [1:0] blk_sel = 2'b11;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       rd_status;
    logic       rmc = 1'b0;
    logic       ist_rd = 1'b0;
    logic       irq_rpf, irq_rme, irq;
    logic [5:0] rbc;

    int checks = 0;
    int fails = 0;
    logic [7:0] model_q[$];
    logic       model_eof[$];
    logic [7:0] seq = 8'h10;

    always #5 clk = ~clk;

    hfc_rx_ctrl dut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
        .wr_eof(wr_eof), .wr_overflow(wr_overflow), .blk_sel(blk_sel),
        .rd_en(rd_en), .rd_data(rd_data), .rd_status(rd_status), .rmc(rmc),
        .ist_rd(ist_rd), .irq_rpf(irq_rpf), .irq_rme(irq_rme), .irq(irq),
        .rbc(rbc)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Write one byte; the bench decides itself whether it must be dropped.
    task automatic push(input logic eof, input logic drop, input string req);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_data  = seq;
        wr_eof   = eof;
        #1;
        chk(req, int'(wr_overflow), int'(drop));
        if (!drop) begin
            model_q.push_back(seq);
            model_eof.push_back(eof);
        end
        seq = seq + 8'd1;
        @(negedge clk);
        wr_valid = 1'b0;
        wr_eof   = 1'b0;
    endtask

    task automatic push_frame(input int n_data, input logic with_status);
        for (int i = 0; i < n_data; i++) push(1'b0, 1'b0, "R4");
        if (with_status) push(1'b1, 1'b0, "R4");
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    // Read n bytes of the offered block and compare them with the model.
    task automatic read_block(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            chk(req, int'(rd_data), int'(model_q[0]));
            chk("R4", int'(rd_status), int'(model_eof[0]));
            void'(model_q.pop_front());
            void'(model_eof.pop_front());
            rd_en = 1'b1;
            @(negedge clk);
            rd_en = 1'b0;
        end
    endtask

    task automatic release_blk();
        rmc = 1'b1;
        @(negedge clk);
        rmc = 1'b0;
        settle();
    endtask

    task automatic clear_irq();
        ist_rd = 1'b1;
        @(negedge clk);
        ist_rd = 1'b0;
    endtask

    task automatic expect_block(input int rpf, input int rme, input int cnt, input string req);
        chk(req, int'(irq_rpf), rpf);
        chk(req, int'(irq_rme), rme);
        chk(req, int'(rbc), cnt);
    endtask

    task automatic t_reset();
        chk("R1", int'(irq), 0);
        chk("R1", int'(irq_rpf), 0);
        chk("R1", int'(irq_rme), 0);
        chk("R1", int'(rbc), 0);
        chk("R1", int'(wr_overflow), 0);
    endtask

    // Full block of data only, for a given select code and size.
    task automatic t_pool(input logic [1:0] sel, input int size);
        blk_sel = sel;
        push_frame(size - 1, 1'b0);
        settle();
        chk("R3 below block", int'(irq), 0);
        push(1'b0, 1'b0, "R3");
        settle();
        expect_block(1, 0, size, "R2 R3");
        read_block(size, "R7");
        clear_irq();
        chk("R11 cleared", int'(irq), 0);
        chk("R11 rpf", int'(irq_rpf), 0);
        release_blk();
        chk("R7 empty after release", int'(irq), 0);
    endtask

    task automatic t_short_frame();
        blk_sel = 2'b01;
        push_frame(3, 1'b1);
        settle();
        expect_block(0, 1, 4, "R5 short");
        chk("R11 irq", int'(irq), 1);
        read_block(4, "R4");
        clear_irq();
        release_blk();
    endtask

    task automatic t_boundary();
        blk_sel = 2'b11;
        push_frame(3, 1'b1);
        settle();
        expect_block(0, 1, 4, "R5 boundary");
        read_block(4, "R5");
        clear_irq();
        release_blk();
    endtask

    task automatic t_queued();
        blk_sel = 2'b01;
        push_frame(2, 1'b1);
        push_frame(1, 1'b1);
        settle();
        expect_block(0, 1, 3, "R8 first frame");
        clear_irq();
        repeat (4) @(negedge clk);
        chk("R6 no new irq", int'(irq), 0);
        chk("R6 rbc held", int'(rbc), 3);
        read_block(3, "R8");
        release_blk();
        expect_block(0, 1, 2, "R8 second frame");
        read_block(2, "R8");
        clear_irq();
        release_blk();
    endtask

    task automatic t_resize();
        blk_sel = 2'b11;
        push_frame(10, 1'b1);
        settle();
        expect_block(1, 0, 4, "R9 first block");
        read_block(4, "R9");
        blk_sel = 2'b01;
        clear_irq();
        release_blk();
        expect_block(0, 1, 7, "R9 new size");
        read_block(7, "R9");
        clear_irq();
        release_blk();
    endtask

    task automatic t_overflow();
        blk_sel = 2'b00;
        push_frame(32, 1'b0);
        push(1'b0, 1'b1, "R10 overflow");
        settle();
        expect_block(1, 0, 32, "R2 R10");
        read_block(32, "R10 data intact");
        clear_irq();
        release_blk();
        chk("R10 empty", int'(irq), 0);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_pool(2'b11, 4);
        t_pool(2'b10, 8);
        t_pool(2'b01, 16);
        t_short_frame();
        t_boundary();
        t_queued();
        t_resize();
        t_overflow();
        finish_run();
    end

endmodule